// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block sets the frame cadence of a full-speed USB host. A down-counter steps once for every bit-time enable. When it has run through a whole frame it raises a start-of-frame strobe for one cycle and loads itself again. The frame length comes from a programmable 14-bit interval. A 15-bit full-speed packet-size limit sits beside it in the same 32-bit register. Both fields are presented to the rest of the host controller.

Software reaches the register through a small command port. The low seven bits of the command pick the register, and the top bit chooses between a write and a read. A write only changes a staged (shadow) copy. The counter and the packet-size output pick up the staged values at the next start-of-frame. This lets software trim the frame length against an external clock once per frame without disturbing the frame already in progress. A read returns the staged values, not the ones in use.

Top module: `usb_frame_timer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `sof_pulse` is 0, `max_pkt` is 0 and `reg_rdata` is 0. The staged interval resets to 11999 and the staged packet limit resets to 0.
- R2: A command is accepted only when `reg_cs` is 1 and `reg_cmd[6:0]` equals 0x0D. Bit 7 set (0x8D) means write and bit 7 clear (0x0D) means read. Any other code, and any command with `reg_cs` at 0, leaves the staged values and `reg_rdata` unchanged.
- R3: Register layout: the interval is in bits 13:0 and the packet limit is in bits 30:16. Bits 31, 15 and 14 always read as 0, and writes to them have no effect.
- R4: A read puts the staged register word on `reg_rdata` one cycle after the command. `reg_rdata` keeps that value until the next accepted read.
- R5: The counter decrements by one on each cycle with `bit_en` at 1 and holds when `bit_en` is 0. No strobe is produced while `bit_en` is 0.
- R6: When the counter is at zero and `bit_en` is 1, `sof_pulse` is high for the following cycle and the counter reloads. With an interval of N, strobes come every N+1 enabled cycles. An interval of 0 strobes on every enabled cycle.
- R7: A written interval does not shorten or stretch the frame in progress. It takes effect at the next strobe.
- R8: `max_pkt` changes only in the cycle in which `sof_pulse` is high, and then takes the staged packet limit.
- R9: A write made in the same cycle as a counter expiry applies at the strobe after the one that expiry produces.
- R10: The first frame after reset lasts 12000 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per full-speed bit time |
| reg_cs | input | 1 | Register command valid |
| reg_cmd | input | 8 | Command code: bit 7 selects write, bits 6:0 select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| max_pkt | output | 15 | Packet-size limit currently in force |

## Verification
The bench builds the block with the default field widths and with the 11999 reset interval. The 12000-cycle first frame is run out in full. Programmed intervals are then kept between 0 and 23, so a few thousand random cycles cover hundreds of frame boundaries. That includes writes that land exactly on an expiry, zero-length intervals that strobe back to back, and writes that set every reserved bit.

// File: rtl/usb_frame_timer_pkg.sv
// Package: shared field geometry and command codes for the frame timer.
// Assumes a 32-bit register with the interval field in the low bits.
package usb_frame_timer_pkg;
    localparam int FT_DATA_W   = 32;
    localparam int FT_IVL_W    = 14;
    localparam int FT_PKT_W    = 15;
    localparam int FT_PKT_LSB  = 16;
    localparam int FT_CMD_W    = 8;
    localparam int FT_REG_ADDR = 'h0D;
    localparam int FT_RST_IVL  = 11999;
endpackage

// File: rtl/usb_frame_timer_regs.sv
// Register port: decodes commands, holds the staged interval and packet limit,
// and returns the staged word on reads. Assumes one command per cycle.
module usb_frame_timer_regs
    import usb_frame_timer_pkg::*;
#(
    parameter int DATA_W  = FT_DATA_W,
    parameter int IVL_W   = FT_IVL_W,
    parameter int PKT_W   = FT_PKT_W,
    parameter int PKT_LSB = FT_PKT_LSB,
    parameter int CMD_W   = FT_CMD_W,
    parameter int ADDR    = FT_REG_ADDR,
    parameter int RST_IVL = FT_RST_IVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [IVL_W-1:0]  stg_ivl,
    output logic [PKT_W-1:0]  stg_pkt
);
    localparam int ADDR_W = CMD_W - 1;

    logic              hit;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] word;

    // Decode: address match on low bits, direction from the top bit.
    always_comb begin
        hit   = cs && (cmd[ADDR_W-1:0] == ADDR_W'(ADDR));
        wr_en = hit && cmd[CMD_W-1];
        rd_en = hit && !cmd[CMD_W-1];
    end

    // Pack the staged fields; reserved positions stay zero.
    always_comb begin
        word = '0;
        word[IVL_W-1:0]       = stg_ivl;
        word[PKT_LSB +: PKT_W] = stg_pkt;
    end

    // Staged register update on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_ivl <= IVL_W'(RST_IVL);
            stg_pkt <= '0;
        end else if (wr_en) begin
            stg_ivl <= wdata[IVL_W-1:0];
            stg_pkt <= wdata[PKT_LSB +: PKT_W];
        end
    end

    // Read data capture, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= word;
        end
    end
endmodule

// File: rtl/usb_frame_timer_count.sv
// Frame counter: counts bit-time enables down, strobes at expiry and loads the
// staged interval and packet limit. Assumes bit_en is at most one per cycle.
module usb_frame_timer_count
    import usb_frame_timer_pkg::*;
#(
    parameter int IVL_W   = FT_IVL_W,
    parameter int PKT_W   = FT_PKT_W,
    parameter int RST_IVL = FT_RST_IVL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [IVL_W-1:0] ld_ivl,
    input  logic [PKT_W-1:0] ld_pkt,
    output logic             sof,
    output logic [PKT_W-1:0] pkt_q,
    output logic [IVL_W-1:0] cnt_q
);
    logic expire;

    // Expiry: counter at zero on an enabled bit time.
    always_comb expire = bit_en && (cnt_q == '0);

    // Down-count, strobe and boundary load of the staged values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= IVL_W'(RST_IVL);
            pkt_q <= '0;
            sof   <= 1'b0;
        end else begin
            sof <= expire;
            if (expire) begin
                cnt_q <= ld_ivl;
                pkt_q <= ld_pkt;
            end else if (bit_en) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_frame_timer.sv
// Top: frame interval timer with staged register and boundary-applied reload.
// Assumes a synchronous active-low reset and a bit-time enable from outside.
module usb_frame_timer
    import usb_frame_timer_pkg::*;
#(
    parameter int DATA_W  = FT_DATA_W,
    parameter int IVL_W   = FT_IVL_W,
    parameter int PKT_W   = FT_PKT_W,
    parameter int PKT_LSB = FT_PKT_LSB,
    parameter int CMD_W   = FT_CMD_W,
    parameter int ADDR    = FT_REG_ADDR,
    parameter int RST_IVL = FT_RST_IVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              reg_cs,
    input  logic [CMD_W-1:0]  reg_cmd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sof_pulse,
    output logic [PKT_W-1:0]  max_pkt
);
    logic [IVL_W-1:0] stg_ivl;
    logic [PKT_W-1:0] stg_pkt;
    logic [IVL_W-1:0] cnt_q;

    usb_frame_timer_regs #(
        .DATA_W(DATA_W), .IVL_W(IVL_W), .PKT_W(PKT_W), .PKT_LSB(PKT_LSB),
        .CMD_W(CMD_W), .ADDR(ADDR), .RST_IVL(RST_IVL)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .cs(reg_cs), .cmd(reg_cmd),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .stg_ivl(stg_ivl), .stg_pkt(stg_pkt)
    );

    usb_frame_timer_count #(
        .IVL_W(IVL_W), .PKT_W(PKT_W), .RST_IVL(RST_IVL)
    ) count_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .ld_ivl(stg_ivl), .ld_pkt(stg_pkt),
        .sof(sof_pulse), .pkt_q(max_pkt), .cnt_q(cnt_q)
    );
endmodule

// File: rtl/usb_frame_timer_chk.sv
// Checker: temporal properties of the frame timer, bound to the top module.
// Assumes the default package geometry.
module usb_frame_timer_chk
    import usb_frame_timer_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_en,
    input logic                 reg_cs,
    input logic [FT_DATA_W-1:0] reg_rdata,
    input logic                 sof_pulse,
    input logic [FT_PKT_W-1:0]  max_pkt,
    input logic [FT_IVL_W-1:0]  cnt_q,
    input logic [FT_IVL_W-1:0]  stg_ivl
);
    localparam logic [FT_DATA_W-1:0] USED =
        (FT_DATA_W'((1 << FT_IVL_W) - 1)) |
        (FT_DATA_W'((1 << FT_PKT_W) - 1) << FT_PKT_LSB);

    AST_SOF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> $past(bit_en)); // R6
    AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> ($past(cnt_q) == '0)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cnt_q != '0) |=> (cnt_q == FT_IVL_W'($past(cnt_q) - 1'b1))); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(cnt_q) && !sof_pulse)); // R5
    AST_RELOAD_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cnt_q == '0) |=> (cnt_q == $past(stg_ivl))); // R7
    AST_PKT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_pulse |-> $stable(max_pkt)); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED) == '0); // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_cs |=> $stable(reg_rdata)); // R4
endmodule

bind usb_frame_timer usb_frame_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_cs(reg_cs),
    .reg_rdata(reg_rdata), .sof_pulse(sof_pulse), .max_pkt(max_pkt),
    .cnt_q(cnt_q), .stg_ivl(stg_ivl)
);

// File: tb/usb_frame_timer_tb.sv
`timescale 1ns/1ps
// Bench: cycle model of the requirements, directed corners plus seeded random.
module usb_frame_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        reg_cs = 1'b0;
    logic [7:0]  reg_cmd = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sof_pulse;
    logic [14:0] max_pkt;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Model state.
    logic [13:0] m_cnt, m_ivl;
    logic [14:0] m_stg_pkt, m_pkt;
    logic        m_sof;
    logic [31:0] m_rd;

    usb_frame_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_cs(reg_cs),
        .reg_cmd(reg_cmd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sof_pulse(sof_pulse), .max_pkt(max_pkt)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pack(input logic [13:0] ivl, input logic [14:0] pkt);
        pack = {1'b0, pkt, 2'b00, ivl};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model update from the driven inputs, compare at the negedge.
    task automatic step();
        logic [13:0] o_ivl;
        logic [14:0] o_pkt;
        logic        hit;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 14'd11999; m_ivl = 14'd11999; m_stg_pkt = '0;
            m_pkt = '0; m_sof = 1'b0; m_rd = '0;
        end else begin
            o_ivl = m_ivl; o_pkt = m_stg_pkt;
            hit = reg_cs && (reg_cmd[6:0] == 7'h0D);
            if (hit && reg_cmd[7]) begin
                m_ivl = reg_wdata[13:0]; m_stg_pkt = reg_wdata[30:16];
            end
            if (hit && !reg_cmd[7]) m_rd = pack(o_ivl, o_pkt);
            m_sof = 1'b0;
            if (bit_en) begin
                if (m_cnt == 0) begin
                    m_sof = 1'b1; m_cnt = o_ivl; m_pkt = o_pkt;
                end else begin
                    m_cnt = m_cnt - 1'b1;
                end
            end
        end
        @(negedge clk);
        chk("R6/R9/R5 sof_pulse", {31'b0, sof_pulse}, {31'b0, m_sof});
        chk("R8 max_pkt", {17'b0, max_pkt}, {17'b0, m_pkt});
        chk("R4/R2 reg_rdata", reg_rdata, m_rd);
    endtask

    task automatic drv(input logic cs, input logic [7:0] cmd, input logic [31:0] wd, input logic be);
        reg_cs = cs; reg_cmd = cmd; reg_wdata = wd; bit_en = be;
        step();
    endtask

    task automatic run_to_sof(output int n);
        n = 0;
        do begin
            drv(1'b0, 8'h00, 32'h0, 1'b1);
            n++;
        end while (!sof_pulse && n < 20000);
    endtask

    initial begin
        int n;
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state.
        for (int i = 0; i < 3; i++) drv(1'b0, 8'h00, 32'h0, 1'b1);
        chk("R1 sof in reset", {31'b0, sof_pulse}, 32'h0);
        chk("R1 max_pkt in reset", {17'b0, max_pkt}, 32'h0);
        rst_n = 1'b1;
        drv(1'b0, 8'h00, 32'h0, 1'b0);
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        drv(1'b1, 8'h0D, 32'h0, 1'b0);
        chk("R1 staged reset word", reg_rdata, pack(14'd11999, 15'd0));
        // R7: stage a short interval; current frame must stay at default.
        drv(1'b1, 8'h8D, pack(14'd7, 15'd64), 1'b0);
        drv(1'b1, 8'h0D, 32'h0, 1'b0);
        chk("R4 read returns staged", reg_rdata, pack(14'd7, 15'd64));
        chk("R8 pkt not yet applied", {17'b0, max_pkt}, 32'h0);
        run_to_sof(n);
        chk("R10 first frame length", n, 12000);
        chk("R8 pkt applied at sof", {17'b0, max_pkt}, 32'd64);
        run_to_sof(n);
        chk("R7 staged interval applied", n, 8);
        // R2: ignored commands.
        drv(1'b1, 8'h8E, pack(14'd3, 15'd1), 1'b0);
        drv(1'b1, 8'h0D, pack(14'd3, 15'd1), 1'b0);
        drv(1'b0, 8'h8D, pack(14'd3, 15'd1), 1'b0);
        drv(1'b1, 8'h0C, 32'h0, 1'b0);
        chk("R2 foreign codes ignored", reg_rdata, pack(14'd7, 15'd64));
        // R3: reserved bits.
        drv(1'b1, 8'h8D, 32'hFFFF_FFFF, 1'b0);
        drv(1'b1, 8'h0D, 32'h0, 1'b0);
        chk("R3 reserved read zero", reg_rdata, 32'h7FFF_3FFF);
        drv(1'b1, 8'h8D, pack(14'd5, 15'd100), 1'b0);
        run_to_sof(n);
        chk("R7 previous interval kept", n, 8);
        // R9: write on the expiry cycle.
        while (m_cnt != 0) drv(1'b0, 8'h00, 32'h0, 1'b1);
        drv(1'b1, 8'h8D, pack(14'd2, 15'd9), 1'b1);
        chk("R9 strobe on expiry", {31'b0, sof_pulse}, 32'h1);
        chk("R9 pkt from older value", {17'b0, max_pkt}, 32'd100);
        run_to_sof(n);
        chk("R9 old interval used", n, 6);
        run_to_sof(n);
        chk("R9 new interval next", n, 3);
        // R5: hold without enable.
        for (int i = 0; i < 20; i++) drv(1'b0, 8'h00, 32'h0, 1'b0);
        chk("R5 no strobe while idle", {31'b0, sof_pulse}, 32'h0);
        // R6: zero interval strobes every enabled cycle.
        drv(1'b1, 8'h8D, pack(14'd0, 15'd5), 1'b0);
        run_to_sof(n);
        drv(1'b0, 8'h00, 32'h0, 1'b1);
        chk("R6 zero interval back to back", {31'b0, sof_pulse}, 32'h1);
        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            logic [7:0]  cmd;
            wd = $urandom;
            wd[13:0] = 14'($urandom % 24);
            case ($urandom % 5)
                0: cmd = 8'h0D;
                1: cmd = 8'h8E;
                2: cmd = 8'h0C;
                default: cmd = 8'h8D;
            endcase
            drv(($urandom % 4) == 0, cmd, wd, $urandom % 2 == 0);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule